// File: doc/BRIEF.md
# Indexed Sprite-Attribute RAM Window

This block sits between a byte-wide host bus and an 8 KB synchronous work RAM. It gives the host a small set of indexed registers for sprite attribute records, so the host does not have to compute RAM addresses itself. The host first picks one of two table bases and latches a record index. It can then reach the four bytes of that record through four fixed register addresses. A fifth register holds a packed byte that carries a 2-bit field for every record. A write to that register changes only the field of the current record, through an internal read, merge and write-back of the byte.

Any other address inside the 8 KB host window reaches the RAM directly. Every write inside the window is also copied to the RAM byte at the host address masked to 13 bits. At reset the block rebuilds its base select, index and shift by reading back the copies that the last register writes left in the RAM.

A 16-bit host access is carried out as two byte accesses: the low byte at the given address, then the high byte at that address plus one. The block lowers its ready signal while an access is in progress and gives a one-cycle done pulse when the access finishes.

Top module: `sprattr_window`

## Requirements
- R1: While reset is held, host_ready is low. After reset is released, the block reads RAM byte 0x1FF5 (bit 0 sets the base select) and RAM byte 0x1FF6 (this byte loads the index and shift as in R5). host_ready rises at the third clock edge after the release.
- R2: A strobe at a host address below 0x6000 or above 0x7FFF is ignored. It causes no RAM access and no done pulse, and host_ready stays high.
- R3: A read of any window address other than 0x7FF0 to 0x7FF4 returns RAM[addr & 0x1FFF]. This includes 0x7FF5 and 0x7FF6.
- R4: A write to 0x7FF5 sets the table base. If data bit 0 is 1 the base is 0x1800; if it is 0 the base is 0x1C00.
- R5: A write to 0x7FF6 sets the record index to data & 0x7F and the field shift to 2 × (data & 3).
- R6: A read or write of 0x7FF0 + n, for n from 0 to 3, reaches RAM[base + 4 × index + n].
- R7: A write to 0x7FF4 reads the byte at base + (index >> 2) + 0x200. It replaces only bits [shift+1:shift] of that byte with data bits [1:0] and writes the byte back.
- R8: A read of 0x7FF4 returns the whole byte at base + (index >> 2) + 0x200.
- R9: Every write inside the window also stores the data byte at RAM[addr & 0x1FFF], after any register effect of that write.
- R10: With host_wide set, the low data byte goes to addr and the high data byte goes to addr + 1, in that order. Read data comes back in the same byte lanes. A second byte that falls outside the window is skipped and reads as 0.
- R11: host_ready is high only when the block is idle. Strobes while host_ready is low are ignored. host_done is a single-cycle pulse, host_rdata is valid during that pulse, and host_ready is high in the next cycle.
- R12: The RAM returns read data one cycle after ram_re. Counted in cycles from acceptance to host_done, a plain write takes 2, a byte read or a record write takes 3, and a 0x7FF4 write takes 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_wide | input | 1 | Marks a 16-bit access |
| host_addr | input | 16 | Host byte address |
| host_wdata | input | 16 | Write data; the low byte is used first |
| host_ready | output | 1 | Block is idle and will accept a strobe |
| host_done | output | 1 | Access finished; read data is valid |
| host_rdata | output | 16 | Read data |
| ram_re | output | 1 | RAM read enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 13 | RAM byte address |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, valid one cycle after ram_re |

## Verification
Directed cases cover each base select and each of the four field shifts. A 0x7FF4 write with neighbouring bits set shows whether the merge is confined to its own two bits, and a reset after register writes shows whether the reload uses the mirrored copies. 16-bit accesses at 0x7FF3, 0x7FF5 and 0x7FFF show the byte order, the byte that crosses from a record register into the packed register, and the byte that leaves the window. Random mixes of base, index, record, field and plain accesses are then compared against a reference array kept by the bench, so that a wrong index scale, a wrong offset or a missing mirror write shows up on later reads.

// File: rtl/sprattr_pkg.sv
package sprattr_pkg;
  localparam int HA_W = 16;
  localparam int RA_W = 13;
  localparam int DW   = 8;
  localparam int IX_W = 7;
  localparam int SH_W = 3;
  localparam int HD_W = 2 * DW;

  localparam logic [HA_W-1:0] WIN_LO   = 16'h6000;
  localparam logic [HA_W-1:0] WIN_HI   = 16'h7FFF;
  localparam logic [HA_W-1:0] REG_REC0 = 16'h7FF0;
  localparam logic [HA_W-1:0] REG_PACK = 16'h7FF4;
  localparam logic [HA_W-1:0] REG_BASE = 16'h7FF5;
  localparam logic [HA_W-1:0] REG_IDX  = 16'h7FF6;

  typedef enum logic [2:0] {K_PLAIN, K_REC, K_PACK, K_BASE, K_IDX} kind_e;

  typedef enum logic [3:0] {
    S_BOOT0, S_BOOT1, S_BOOT2, S_IDLE, S_ISSUE,
    S_RDCAP, S_MERGE, S_MIRROR, S_STEP
  } state_e;

  function automatic logic in_window(input logic [HA_W-1:0] a);
    return (a >= WIN_LO) && (a <= WIN_HI);
  endfunction

  function automatic logic [SH_W-1:0] field_shift(input logic [1:0] lo);
    return {lo, 1'b0};
  endfunction

  function automatic logic [RA_W-1:0] rec_offset(input logic [IX_W-1:0] idx,
                                                 input logic [1:0] lane);
    return RA_W'({idx, lane});
  endfunction

  function automatic logic [RA_W-1:0] pack_offset(input logic [IX_W-1:0] idx);
    return RA_W'(idx >> 2);
  endfunction
endpackage

// File: rtl/sprattr_decode.sv
module sprattr_decode
  import sprattr_pkg::*;
(
  input  logic [HA_W-1:0] addr,
  output logic            in_win,
  output kind_e           kind,
  output logic [1:0]      lane,
  output logic [RA_W-1:0] mirror
);
  always_comb begin
    in_win = in_window(addr);
    lane   = addr[1:0];
    mirror = addr[RA_W-1:0];
    kind   = K_PLAIN;
    if (addr >= REG_REC0 && addr < REG_PACK) kind = K_REC;
    else if (addr == REG_PACK)               kind = K_PACK;
    else if (addr == REG_BASE)               kind = K_BASE;
    else if (addr == REG_IDX)                kind = K_IDX;
  end

  // R2
  always_comb begin
    win_bits_chk: assert (!in_win || addr[HA_W-1:RA_W] == 3'b011);
  end
endmodule

// File: rtl/sprattr_ctx.sv
module sprattr_ctx
  import sprattr_pkg::*;
#(
  parameter logic [RA_W-1:0] BASE_SET = 13'h1800,
  parameter logic [RA_W-1:0] BASE_CLR = 13'h1C00,
  parameter logic [RA_W-1:0] HI_OFS   = 13'h0200
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld_base,
  input  logic            ld_idx,
  input  logic [IX_W-1:0] din,
  input  logic [1:0]      lane,
  output logic [SH_W-1:0] shift,
  output logic [RA_W-1:0] rec_addr,
  output logic [RA_W-1:0] pack_addr
);
  logic            sel_q;
  logic [IX_W-1:0] idx_q;
  logic [SH_W-1:0] sh_q;
  logic [RA_W-1:0] base;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      idx_q <= '0;
      sh_q  <= '0;
    end else begin
      if (ld_base) sel_q <= din[0];
      if (ld_idx) begin
        idx_q <= din;
        sh_q  <= field_shift(din[1:0]);
      end
    end
  end

  always_comb begin
    base      = sel_q ? BASE_SET : BASE_CLR;
    rec_addr  = base + rec_offset(idx_q, lane);
    pack_addr = base + HI_OFS + pack_offset(idx_q);
    shift     = sh_q;
  end

  // R5
  shift_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift[0] == 1'b0);

  // R5
  shift_tracks_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_idx |=> shift[2:1] == idx_q[1:0]);
endmodule

// File: rtl/sprattr_fieldmerge.sv
module sprattr_fieldmerge
  import sprattr_pkg::*;
(
  input  logic [DW-1:0]   old_byte,
  input  logic [SH_W-1:0] shift,
  input  logic [1:0]      bits,
  output logic [DW-1:0]   new_byte
);
  localparam int NF = DW / 2;

  for (genvar g = 0; g < NF; g++) begin : g_field
    assign new_byte[2*g +: 2] = (shift == SH_W'(2*g)) ? bits : old_byte[2*g +: 2];
  end
endmodule

// File: rtl/sprattr_window.sv
module sprattr_window
  import sprattr_pkg::*;
#(
  parameter logic [RA_W-1:0] BASE_SET    = 13'h1800,
  parameter logic [RA_W-1:0] BASE_CLR    = 13'h1C00,
  parameter logic [RA_W-1:0] HI_OFS      = 13'h0200,
  parameter logic [RA_W-1:0] CFG_SEL_LOC = 13'h1FF5,
  parameter logic [RA_W-1:0] CFG_IDX_LOC = 13'h1FF6
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            host_rd,
  input  logic            host_wr,
  input  logic            host_wide,
  input  logic [HA_W-1:0] host_addr,
  input  logic [HD_W-1:0] host_wdata,
  output logic            host_ready,
  output logic            host_done,
  output logic [HD_W-1:0] host_rdata,
  output logic            ram_re,
  output logic            ram_we,
  output logic [RA_W-1:0] ram_addr,
  output logic [DW-1:0]   ram_wdata,
  input  logic [DW-1:0]   ram_rdata
);
  state_e          state;
  logic            req_wr, req_wide, lane_hi;
  logic [HA_W-1:0] cur_addr;
  logic [HD_W-1:0] wbuf, rbuf;
  logic [DW-1:0]   cur_data;
  logic [HA_W-1:0] next_addr;
  logic            accept, step_more;

  logic            dec_win;
  kind_e           dec_kind;
  logic [1:0]      dec_lane;
  logic [RA_W-1:0] dec_mirror;

  logic            ld_base, ld_idx;
  logic [IX_W-1:0] ctx_din;
  logic [SH_W-1:0] ctx_shift;
  logic [RA_W-1:0] rec_addr, pack_addr;
  logic [DW-1:0]   merged;

  sprattr_decode u_dec (
    .addr(cur_addr), .in_win(dec_win), .kind(dec_kind),
    .lane(dec_lane), .mirror(dec_mirror)
  );

  sprattr_ctx #(.BASE_SET(BASE_SET), .BASE_CLR(BASE_CLR), .HI_OFS(HI_OFS)) u_ctx (
    .clk(clk), .rst_n(rst_n), .ld_base(ld_base), .ld_idx(ld_idx),
    .din(ctx_din), .lane(dec_lane), .shift(ctx_shift),
    .rec_addr(rec_addr), .pack_addr(pack_addr)
  );

  sprattr_fieldmerge u_merge (
    .old_byte(ram_rdata), .shift(ctx_shift), .bits(cur_data[1:0]), .new_byte(merged)
  );

  assign cur_data   = lane_hi ? wbuf[HD_W-1:DW] : wbuf[DW-1:0];
  assign next_addr  = cur_addr + 1'b1;
  assign accept     = (state == S_IDLE) && (host_rd || host_wr) && in_window(host_addr);
  assign step_more  = req_wide && !lane_hi && in_window(next_addr);
  assign host_ready = (state == S_IDLE);
  assign host_done  = (state == S_STEP) && !step_more;
  assign host_rdata = rbuf;

  always_comb begin
    ram_re    = 1'b0;
    ram_we    = 1'b0;
    ram_addr  = dec_mirror;
    ram_wdata = cur_data;
    ld_base   = 1'b0;
    ld_idx    = 1'b0;
    ctx_din   = cur_data[IX_W-1:0];
    case (state)
      S_BOOT0: begin
        ram_re   = 1'b1;
        ram_addr = CFG_SEL_LOC;
      end
      S_BOOT1: begin
        ram_re   = 1'b1;
        ram_addr = CFG_IDX_LOC;
        ld_base  = 1'b1;
        ctx_din  = ram_rdata[IX_W-1:0];
      end
      S_BOOT2: begin
        ld_idx  = 1'b1;
        ctx_din = ram_rdata[IX_W-1:0];
      end
      S_ISSUE: begin
        if (!req_wr) begin
          ram_re = 1'b1;
          if (dec_kind == K_REC)       ram_addr = rec_addr;
          else if (dec_kind == K_PACK) ram_addr = pack_addr;
        end else begin
          case (dec_kind)
            K_REC:  begin ram_we = 1'b1; ram_addr = rec_addr; end
            K_PACK: begin ram_re = 1'b1; ram_addr = pack_addr; end
            K_BASE: begin ld_base = 1'b1; ram_we = 1'b1; end
            K_IDX:  begin ld_idx = 1'b1; ram_we = 1'b1; end
            default: ram_we = 1'b1;
          endcase
        end
      end
      S_MERGE: begin
        ram_we    = 1'b1;
        ram_addr  = pack_addr;
        ram_wdata = merged;
      end
      S_MIRROR: ram_we = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_BOOT0;
      req_wr   <= 1'b0;
      req_wide <= 1'b0;
      lane_hi  <= 1'b0;
      cur_addr <= '0;
      wbuf     <= '0;
      rbuf     <= '0;
    end else begin
      case (state)
        S_BOOT0: state <= S_BOOT1;
        S_BOOT1: state <= S_BOOT2;
        S_BOOT2: state <= S_IDLE;
        S_IDLE: if (accept) begin
          req_wr   <= host_wr;
          req_wide <= host_wide;
          cur_addr <= host_addr;
          wbuf     <= host_wdata;
          lane_hi  <= 1'b0;
          rbuf     <= '0;
          state    <= S_ISSUE;
        end
        S_ISSUE: begin
          if (!req_wr)                state <= S_RDCAP;
          else if (dec_kind == K_REC)  state <= S_MIRROR;
          else if (dec_kind == K_PACK) state <= S_MERGE;
          else                         state <= S_STEP;
        end
        S_RDCAP: begin
          if (lane_hi) rbuf[HD_W-1:DW] <= ram_rdata;
          else         rbuf[DW-1:0]    <= ram_rdata;
          state <= S_STEP;
        end
        S_MERGE:  state <= S_MIRROR;
        S_MIRROR: state <= S_STEP;
        S_STEP: begin
          if (step_more) begin
            cur_addr <= next_addr;
            lane_hi  <= 1'b1;
            state    <= S_ISSUE;
          end else begin
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  logic [DW-1:0] fmask;
  assign fmask = DW'(2'b11) << ctx_shift;

  // R12
  rmw_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_MERGE) |-> ($past(ram_re) && ram_addr == $past(ram_addr)));

  // R7
  packed_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_MERGE) |-> (((ram_wdata ^ ram_rdata) & ~fmask) == '0));

  // R11
  busy_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we || ram_re) |-> !host_ready);

  // R11
  done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_done |=> host_ready);

  // R9
  mirror_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_STEP && req_wr) |->
      ($past(ram_we) && $past(ram_addr) == cur_addr[RA_W-1:0] && $past(ram_wdata) == cur_data));
endmodule

// File: tb/test_sprattr_window.sv
module test_sprattr_window;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_rd = 1'b0, host_wr = 1'b0, host_wide = 1'b0;
  logic [15:0] host_addr = '0, host_wdata = '0;
  logic        host_ready, host_done;
  logic [15:0] host_rdata;
  logic        ram_re, ram_we;
  logic [12:0] ram_addr;
  logic [7:0]  ram_wdata;
  logic [7:0]  ram_rdata = '0;

  int total = 0, bad = 0;
  int last_rd, last_lat;
  logic [7:0] sram [int];
  logic [7:0] refm [int];
  int rb_sel, r_idx;

  always #5 clk = ~clk;

  sprattr_window i_sprattr_window (
    .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .host_wr(host_wr),
    .host_wide(host_wide), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_ready(host_ready), .host_done(host_done), .host_rdata(host_rdata),
    .ram_re(ram_re), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
  );

  always @(posedge clk) begin
    if (ram_re) ram_rdata <= sram.exists(int'(ram_addr)) ? sram[int'(ram_addr)] : 8'h00;
    if (ram_we) sram[int'(ram_addr)] = ram_wdata;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int rget(input int a);
    return refm.exists(a) ? int'(refm[a]) : 0;
  endfunction

  function automatic int rbase();
    return (rb_sel != 0) ? 'h1800 : 'h1C00;
  endfunction

  function automatic bit inwin(input int a);
    return a >= 'h6000 && a <= 'h7FFF;
  endfunction

  function automatic int ref_rd_byte(input int a);
    if (!inwin(a)) return 0;
    if (a >= 'h7FF0 && a <= 'h7FF3) return rget(rbase() + r_idx * 4 + (a - 'h7FF0));
    if (a == 'h7FF4) return rget(rbase() + r_idx / 4 + 'h200);
    return rget(a % 'h2000);
  endfunction

  function automatic void ref_wr_byte(input int a, input int d);
    int p, old, sh;
    if (!inwin(a)) return;
    if (a >= 'h7FF0 && a <= 'h7FF3) refm[rbase() + r_idx * 4 + (a - 'h7FF0)] = 8'(d);
    else if (a == 'h7FF4) begin
      p   = rbase() + r_idx / 4 + 'h200;
      old = rget(p);
      sh  = (r_idx % 4) * 2;
      refm[p] = 8'((old & ~(3 << sh)) | ((d & 3) << sh));
    end else if (a == 'h7FF5) rb_sel = d & 1;
    else if (a == 'h7FF6) r_idx = d & 'h7F;
    refm[a % 'h2000] = 8'(d);
  endfunction

  function automatic int ref_access(input bit wr, input bit wide, input int a, input int d);
    int res = 0;
    int a1 = (a + 1) % 'h10000;
    if (wr) begin
      ref_wr_byte(a, d & 'hFF);
      if (wide && inwin(a)) ref_wr_byte(a1, (d >> 8) & 'hFF);
    end else begin
      res = ref_rd_byte(a);
      if (wide && inwin(a)) res = res | (ref_rd_byte(a1) << 8);
    end
    return res;
  endfunction

  task automatic xfer(input bit wr, input bit wide, input int a, input int d);
    while (!host_ready) @(negedge clk);
    host_rd = !wr; host_wr = wr; host_wide = wide;
    host_addr = a[15:0]; host_wdata = d[15:0];
    @(negedge clk);
    host_rd = 1'b0; host_wr = 1'b0; host_wide = 1'b0;
    last_lat = 1;
    while (!host_done) begin @(negedge clk); last_lat++; end
    last_rd = int'(host_rdata);
  endtask

  task automatic do_wr(input bit wide, input int a, input int d);
    int unused;
    unused = ref_access(1'b1, wide, a, d);
    xfer(1'b1, wide, a, d);
  endtask

  task automatic do_rd(input string req, input bit wide, input int a);
    int exp;
    exp = ref_access(1'b0, wide, a, 0);
    xfer(1'b0, wide, a, 0);
    chk(req, last_rd, exp);
  endtask

  task automatic boot(input string req);
    int n = 0;
    @(negedge clk);
    chk({req, " ready low in reset"}, int'(host_ready), 0);
    rst_n = 1'b1;
    rb_sel = rget('h1FF5) & 1;
    r_idx  = rget('h1FF6) & 'h7F;
    while (!host_ready) begin @(negedge clk); n++; end
    chk({req, " boot cycles"}, n, 3);
  endtask

  initial begin
    int seen;
    void'($urandom(32'd4242));
    for (int a = 'h1800; a < 'h2000; a++) begin
      logic [7:0] v = 8'($urandom);
      sram[a] = v; refm[a] = v;
    end
    sram['h1FF5] = 8'h03; refm['h1FF5] = 8'h03;
    sram['h1FF6] = 8'hAE; refm['h1FF6] = 8'hAE;
    repeat (3) @(negedge clk);
    boot("R1");

    // R1: reload gave base 0x1800, index 0x2E
    for (int n = 0; n < 4; n++) do_rd("R1 record after reset", 1'b0, 'h7FF0 + n);
    do_rd("R8 packed read", 1'b0, 'h7FF4);

    // R4 both base selects
    do_wr(1'b0, 'h7FF5, 'h00);
    do_rd("R4 base clear record", 1'b0, 'h7FF1);
    do_wr(1'b0, 'h7FF5, 'h01);
    do_rd("R4 base set record", 1'b0, 'h7FF1);

    // R5 index and shift at the top index
    do_wr(1'b0, 'h7FF6, 'hFF);
    do_wr(1'b0, 'h7FF3, 'h5C);
    do_rd("R6 record byte 3 at index 0x7F", 1'b0, 'h7FF3);
    chk("R6 record write lands at base+4*idx+3", int'(sram['h1800 + 'h7F * 4 + 3]), 'h5C);

    // R7 every shift keeps the other fields
    for (int k = 0; k < 4; k++) begin
      do_wr(1'b0, 'h7FF6, 'h40 | k);
      do_wr(1'b0, 'h7FF4, 'hFE);
      do_rd("R7 field merge", 1'b0, 'h7FF4);
      do_wr(1'b0, 'h7FF4, 'h01);
      do_rd("R5 shift from index", 1'b0, 'h7FF4);
    end

    // R3 plain reads including register mirrors
    do_rd("R3 plain read", 1'b0, 'h6123);
    do_rd("R3 read of 0x7FF6 is RAM", 1'b0, 'h7FF6);
    do_rd("R3 read of 0x7FF5 is RAM", 1'b0, 'h7FF5);

    // R9 mirror writes seen at the RAM port
    do_wr(1'b0, 'h7FF0, 'h9A);
    chk("R9 mirror of 0x7FF0", int'(sram['h1FF0]), 'h9A);
    do_wr(1'b0, 'h7FF4, 'h3D);
    chk("R9 mirror of 0x7FF4", int'(sram['h1FF4]), 'h3D);

    // R1 reset reload from mirrored register bytes
    do_wr(1'b0, 'h7FF6, 'h15);
    do_wr(1'b0, 'h7FF5, 'h00);
    @(negedge clk); rst_n = 1'b0;
    boot("R1 reload");
    do_rd("R1 reload record", 1'b0, 'h7FF2);
    do_rd("R1 reload packed", 1'b0, 'h7FF4);

    // R10 16-bit accesses
    do_wr(1'b1, 'h7FF5, 'h2201);
    do_rd("R10 wide record read", 1'b1, 'h7FF0);
    do_wr(1'b1, 'h7FF3, 'h0366);
    do_rd("R10 wide crossing into packed", 1'b1, 'h7FF3);
    do_rd("R10 wide read leaving window", 1'b1, 'h7FFF);
    do_wr(1'b1, 'h6300, 'hBEEF);
    do_rd("R10 byte order", 1'b1, 'h6300);
    do_rd("R10 low byte alone", 1'b0, 'h6300);

    // R2 out-of-window strobes
    for (int t = 0; t < 2; t++) begin
      seen = 0;
      host_wr = 1'b1; host_addr = (t == 0) ? 16'h4123 : 16'h8123; host_wdata = 16'h005A;
      @(negedge clk); host_wr = 1'b0;
      for (int c = 0; c < 4; c++) begin
        if (ram_we || ram_re || host_done || !host_ready) seen++;
        @(negedge clk);
      end
      chk("R2 no activity outside window", seen, 0);
    end
    do_rd("R2 mirror target untouched", 1'b0, 'h6123);

    // R11 strobe while busy is ignored, done is one cycle
    while (!host_ready) @(negedge clk);
    void'(ref_access(1'b1, 1'b0, 'h6200, 'h11));
    host_wr = 1'b1; host_addr = 16'h6200; host_wdata = 16'h0011;
    @(negedge clk);
    chk("R11 ready low while busy", int'(host_ready), 0);
    host_addr = 16'h6201; host_wdata = 16'h0099;
    @(negedge clk); host_wr = 1'b0;
    while (!host_done) @(negedge clk);
    @(negedge clk);
    chk("R11 done single cycle", int'(host_done), 0);
    chk("R11 ready after done", int'(host_ready), 1);
    do_rd("R11 busy strobe ignored", 1'b0, 'h6201);

    // R12 latencies
    do_wr(1'b0, 'h6400, 'h12);
    chk("R12 plain write cycles", last_lat, 2);
    do_rd("R12 read data", 1'b0, 'h6400);
    chk("R12 read cycles", last_lat, 3);
    do_wr(1'b0, 'h7FF1, 'h44);
    chk("R12 record write cycles", last_lat, 3);
    do_wr(1'b0, 'h7FF4, 'h02);
    chk("R12 packed write cycles", last_lat, 4);

    // random mix
    for (int i = 0; i < 500; i++) begin
      int op = $urandom_range(0, 9);
      int d  = int'($urandom & 32'hFFFF);
      case (op)
        0: do_wr(1'b0, 'h7FF5, d & 'hFF);
        1: do_wr(1'b0, 'h7FF6, d & 'hFF);
        2: do_wr(1'b0, 'h7FF0 + $urandom_range(0, 3), d & 'hFF);
        3: do_wr(1'b0, 'h7FF4, d & 'hFF);
        4: do_rd("R6 random register read", 1'b0, 'h7FF0 + $urandom_range(0, 4));
        5: do_rd("R3 random plain read", 1'b0, 'h6000 + int'($urandom & 32'h1FFF));
        6: do_wr(1'b0, 'h7800 + int'($urandom_range(0, 'h7EF)), d & 'hFF);
        7: do_rd("R10 random wide read", 1'b1, 'h7FF0 + $urandom_range(0, 4));
        8: do_wr(1'b1, 'h7FF0 + $urandom_range(0, 5), d);
        default: do_rd("R8 random packed read", 1'b0, 'h7FF4);
      endcase
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule